// File: doc/BRIEF.md
# SMBus Line Monitor with Bus-Free and SCL-Low Timeouts

This block watches the clock and data lines of a two-wire SMBus and tells a local controller what the bus is doing. Both lines pass through a two-stage synchronizer. The block then detects START and STOP conditions and keeps a busy flag. Two timers run beside the condition detector. The bus-free timer declares the bus idle once both lines have stayed high long enough, and it clears busy even if no STOP was seen. The SCL-low timer reloads while SCL is high and counts down while SCL is low. When it expires, it raises a sticky timeout flag.

A small state machine produces the drive-timing strobes that a byte engine uses. After each SCL falling edge it waits a hold interval and pulses `hold_strb_o`, which means SDA may now change. It then waits a setup interval and pulses `setup_strb_o`, which means SCL may now be released. There are two pairs of interval lengths, and a configuration bit picks one. An interrupt request pulses on START, on STOP and on an SCL-low timeout. A slave-inhibit bit masks this interrupt, so the device behaves as if it were not on the bus. Byte shifting and address matching belong to other blocks.

The state machine has three states. ST_IDLE waits for an SCL fall. On that fall it moves to ST_HOLD. ST_HOLD moves to ST_SETUP when the hold count completes. ST_SETUP returns to ST_IDLE when the setup count completes. Clearing the enable bit forces ST_IDLE from any state.

Top module: `smb_line_watch`

## Requirements
- R1: With the enable bit (config bit 2) at 0, bus activity on SCL and SDA has no effect. Busy stays 0. No interrupt, no strobe, no bus-free pulse and no timeout flag is produced.
- R2: A START condition sets busy and gives one single-cycle interrupt pulse. A START is SDA falling while SCL is high.
- R3: A STOP condition clears busy and gives one single-cycle interrupt pulse. A STOP is SDA rising while SCL is high.
- R4: The bus-free timer runs when the free-timeout enable (config bit 6) is 1. When both synchronized lines have been high for FREE_CYC consecutive cycles, `free_to_o` pulses once and busy clears. A low level on either line restarts the count. With the enable at 0, busy is never cleared this way.
- R5: The SCL-low timer runs when its enable (config bit 5) is 1. A continuous SCL low of LOW_CYC cycles sets the timeout flag and gives one interrupt pulse. Any shorter low never does, because the timer reloads whenever SCL is high.
- R6: The timeout flag stays set until a one-cycle pulse on `tmo_clr` clears it.
- R7: With slave-inhibit (config bit 3) at 1, START, STOP and timeout events raise no interrupt. Busy and the timeout flag still behave normally.
- R8: With the timing-extension bit (config bit 4) at 0, the hold interval is 3 cycles and the setup interval is 4. The bench measures from the clock edge after SCL is driven low. `hold_strb_o` is high for one cycle at the 5th cycle, which is the hold interval plus 2 synchronizer cycles. `setup_strb_o` is high for one cycle 4 cycles later.
- R9: With the timing-extension bit at 1, the hold interval is 12 cycles and the setup interval is 11. `hold_strb_o` is high at the 14th cycle and `setup_strb_o` at the 25th cycle, each for one cycle.
- R10: `cfg_rdata` returns the written bits [6:2]. It returns the live busy flag in bit 7, and writes to bit 7 are ignored. Bits [1:0] always read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration and busy readback |
| tmo_clr | input | 1 | Clears the SCL-low timeout flag |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| busy_o | output | 1 | Transfer in progress |
| free_to_o | output | 1 | One-cycle pulse when the bus-free interval elapses |
| tmo_flag_o | output | 1 | Sticky SCL-low timeout flag |
| irq_o | output | 1 | One-cycle interrupt request pulse |
| hold_strb_o | output | 1 | Hold interval complete; SDA may change |
| setup_strb_o | output | 1 | Setup interval complete; SCL may be released |

## Verification
A wrong busy state shows on `busy_o` and in bit 7 of `cfg_rdata` within three cycles of the line event that should have changed it. A stale condition-detector register shows up as a START or STOP that is missed or seen twice. That error appears as a wrong interrupt pulse count one cycle later. A timer that fails to reload or restart shows as a bus-free pulse or timeout flag that comes early, comes late or never comes. The bench holds the lines well inside and well outside each interval to expose this. A wrong strobe state or count appears as a strobe at the wrong cycle, so the bench records the exact cycle of every strobe after an SCL fall.

// File: rtl/smb_watch_pkg.sv
package smb_watch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SETUP = 2'd2
    } drv_state_e;

    // configuration bits [6:2], most significant first
    typedef struct packed {
        logic free_en;   // bit 6
        logic low_en;    // bit 5
        logic ext;       // bit 4
        logic inh;       // bit 3
        logic en;        // bit 2
    } cfg_t;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det #(
    parameter int FREE_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic free_en,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic scl_fall_o,
    output logic free_fire_o,
    output logic busy_o
);
    localparam int FW = $clog2(FREE_CYC + 1);

    logic          scl_q, sda_q;
    logic [FW-1:0] free_cnt;
    logic          both_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign start_o    = en & scl_s & scl_q & sda_q & ~sda_s;
    assign stop_o     = en & scl_s & scl_q & ~sda_q & sda_s;
    assign scl_fall_o = en & scl_q & ~scl_s;
    assign both_hi    = scl_s & sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_cnt <= '0;
        end else if (!en || !free_en || !both_hi) begin
            free_cnt <= '0;
        end else if (free_cnt != FW'(FREE_CYC)) begin
            free_cnt <= free_cnt + 1'b1;
        end
    end

    assign free_fire_o = en & free_en & both_hi & (free_cnt == FW'(FREE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
        end else if (!en) begin
            busy_o <= 1'b0;
        end else if (start_o) begin
            busy_o <= 1'b1;
        end else if (stop_o || free_fire_o) begin
            busy_o <= 1'b0;
        end
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> busy_o);
    p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !busy_o);
    p_free_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        free_fire_o |=> !busy_o);
endmodule

// File: rtl/smb_scl_low_tmo.sv
module smb_scl_low_tmo #(
    parameter int LOW_CYC = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic low_en,
    input  logic scl_s,
    input  logic clr,
    output logic fire_o,
    output logic flag_o
);
    localparam int LW = $clog2(LOW_CYC + 1);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= LW'(LOW_CYC);
        end else if (!en || !low_en || scl_s) begin
            low_cnt <= LW'(LOW_CYC);
        end else if (low_cnt != '0) begin
            low_cnt <= low_cnt - 1'b1;
        end
    end

    assign fire_o = en & low_en & ~scl_s & (low_cnt == LW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (fire_o) begin
            flag_o <= 1'b1;
        end else if (clr) begin
            flag_o <= 1'b0;
        end
    end

    p_fire_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> flag_o);
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr) |=> flag_o);
endmodule

// File: rtl/smb_drv_timing.sv
module smb_drv_timing
    import smb_watch_pkg::*;
#(
    parameter int HOLD_SHORT  = 3,
    parameter int SETUP_SHORT = 4,
    parameter int HOLD_LONG   = 12,
    parameter int SETUP_LONG  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ext,
    input  logic scl_fall,
    output logic hold_strb_o,
    output logic setup_strb_o
);
    localparam int MAXL = (HOLD_LONG > SETUP_LONG) ? HOLD_LONG : SETUP_LONG;
    localparam int CW   = $clog2(MAXL + 1);

    drv_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] hold_last, setup_last;

    assign hold_last  = ext ? CW'(HOLD_LONG - 1)  : CW'(HOLD_SHORT - 1);
    assign setup_last = ext ? CW'(SETUP_LONG - 1) : CW'(SETUP_SHORT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state != nxt) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (scl_fall)          nxt = ST_HOLD;
            ST_HOLD:  if (cnt == hold_last)  nxt = ST_SETUP;
            ST_SETUP: if (cnt == setup_last) nxt = ST_IDLE;
            default:                         nxt = ST_IDLE;
        endcase
        if (!en) nxt = ST_IDLE;
    end

    always_comb begin
        hold_strb_o  = 1'b0;
        setup_strb_o = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_HOLD:  hold_strb_o  = (cnt == hold_last);
            ST_SETUP: setup_strb_o = (cnt == setup_last);
            default:  ;
        endcase
    end

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hold_strb_o, setup_strb_o}));
    p_setup_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_strb_o && en) |=> (state == ST_SETUP));
endmodule

// File: rtl/smb_line_watch.sv
module smb_line_watch
    import smb_watch_pkg::*;
#(
    parameter int FREE_CYC    = 10000,
    parameter int LOW_CYC     = 5000000,
    parameter int HOLD_SHORT  = 3,
    parameter int SETUP_SHORT = 4,
    parameter int HOLD_LONG   = 12,
    parameter int SETUP_LONG  = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       tmo_clr,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       busy_o,
    output logic       free_to_o,
    output logic       tmo_flag_o,
    output logic       irq_o,
    output logic       hold_strb_o,
    output logic       setup_strb_o
);
    cfg_t       cfg;
    logic [1:0] lines_s;
    logic       start_w, stop_w, fall_w, free_w, low_fire_w;
    logic       wr_unused;

    assign wr_unused = ^{cfg_wdata[7], cfg_wdata[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg <= '0;
        else if (cfg_we) cfg <= cfg_t'(cfg_wdata[6:2]);
    end

    assign cfg_rdata = {busy_o, cfg, 2'b00};

    smb_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({scl_i, sda_i}), .q_o(lines_s)
    );

    smb_cond_det #(.FREE_CYC(FREE_CYC)) u_cond (
        .clk(clk), .rst_n(rst_n), .en(cfg.en), .free_en(cfg.free_en),
        .scl_s(lines_s[1]), .sda_s(lines_s[0]),
        .start_o(start_w), .stop_o(stop_w), .scl_fall_o(fall_w),
        .free_fire_o(free_w), .busy_o(busy_o)
    );

    smb_scl_low_tmo #(.LOW_CYC(LOW_CYC)) u_low (
        .clk(clk), .rst_n(rst_n), .en(cfg.en), .low_en(cfg.low_en),
        .scl_s(lines_s[1]), .clr(tmo_clr),
        .fire_o(low_fire_w), .flag_o(tmo_flag_o)
    );

    smb_drv_timing #(
        .HOLD_SHORT(HOLD_SHORT), .SETUP_SHORT(SETUP_SHORT),
        .HOLD_LONG(HOLD_LONG), .SETUP_LONG(SETUP_LONG)
    ) u_drv (
        .clk(clk), .rst_n(rst_n), .en(cfg.en), .ext(cfg.ext),
        .scl_fall(fall_w),
        .hold_strb_o(hold_strb_o), .setup_strb_o(setup_strb_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            free_to_o <= 1'b0;
        end else begin
            irq_o     <= cfg.en & ~cfg.inh & (start_w | stop_w | low_fire_w);
            free_to_o <= free_w;
        end
    end

    p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.en && $past(!cfg.en)) |-> (!irq_o && !hold_strb_o && !setup_strb_o && !busy_o));
    p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.inh && $past(cfg.inh)) |-> !irq_o);
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[1:0] == 2'b00);
endmodule

// File: tb/smb_line_watch_tb_top.sv
`timescale 1ns/1ps
module smb_line_watch_tb_top;
    localparam int FREE_T = 20;
    localparam int LOW_T  = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       tmo_clr = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       busy, free_to, tmo_flag, irq, hold_strb, setup_strb;

    int n_chk = 0, n_bad = 0;
    int irq_cnt = 0, free_cnt = 0, strb_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    smb_line_watch #(.FREE_CYC(FREE_T), .LOW_CYC(LOW_T)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tmo_clr(tmo_clr), .scl_i(scl), .sda_i(sda),
        .busy_o(busy), .free_to_o(free_to), .tmo_flag_o(tmo_flag), .irq_o(irq),
        .hold_strb_o(hold_strb), .setup_strb_o(setup_strb)
    );

    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (free_to) free_cnt++;
        if (hold_strb || setup_strb) strb_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
        step(2);
    endtask

    task automatic t_reset;
        chk("R10 reset readback", cfg_rdata, 0);
        chk("R2 reset busy", busy, 0);
        chk("R6 reset flag", tmo_flag, 0);
        chk("R1 reset irq", irq, 0);
    endtask

    task automatic t_disabled_r1;
        int i0 = irq_cnt, s0 = strb_cnt, f0 = free_cnt;
        wr_cfg(8'h60);
        sda = 1'b0; step(4);
        scl = 1'b0; step(100);
        scl = 1'b1; step(4);
        sda = 1'b1; step(40);
        chk("R1 busy", busy, 0);
        chk("R1 irq count", irq_cnt - i0, 0);
        chk("R1 strobes", strb_cnt - s0, 0);
        chk("R1 free pulses", free_cnt - f0, 0);
        chk("R1 flag", tmo_flag, 0);
    endtask

    task automatic t_start_r2;
        int i0;
        wr_cfg(8'h24);
        i0 = irq_cnt;
        sda = 1'b0; step(5);
        chk("R2 busy after START", busy, 1);
        chk("R2 one irq", irq_cnt - i0, 1);
    endtask

    task automatic t_stop_r3;
        int i0 = irq_cnt;
        scl = 1'b0; step(3);
        scl = 1'b1; step(3);
        sda = 1'b1; step(5);
        chk("R3 busy after STOP", busy, 0);
        chk("R3 one irq", irq_cnt - i0, 1);
    endtask

    task automatic t_free_r4;
        int f0;
        sda = 1'b0; step(4);
        scl = 1'b0; step(3);
        sda = 1'b1; step(3);
        scl = 1'b1; step(60);
        chk("R4 disabled keeps busy", busy, 1);
        f0 = free_cnt;
        wr_cfg(8'h64);
        step(6);
        chk("R4 busy before interval", busy, 1);
        step(24);
        chk("R4 busy cleared", busy, 0);
        chk("R4 one free pulse", free_cnt - f0, 1);
        sda = 1'b0; step(4);
        sda = 1'b1; scl = 1'b0; step(3);
        scl = 1'b1; step(12);
        scl = 1'b0; step(3);
        scl = 1'b1; step(12);
        chk("R4 low restarts count", busy, 1);
        step(25);
        chk("R4 busy cleared after restart", busy, 0);
    endtask

    task automatic t_low_r5;
        int i0 = irq_cnt;
        scl = 1'b0; step(20);
        scl = 1'b1; step(5);
        chk("R5 short low no flag", tmo_flag, 0);
        scl = 1'b0; step(25);
        scl = 1'b1; step(5);
        chk("R5 reload on high", tmo_flag, 0);
        chk("R5 no irq on short lows", irq_cnt - i0, 0);
        scl = 1'b0; step(50);
        chk("R5 flag after long low", tmo_flag, 1);
        chk("R5 one irq", irq_cnt - i0, 1);
        scl = 1'b1; step(5);
    endtask

    task automatic t_clear_r6;
        step(10);
        chk("R6 flag sticky", tmo_flag, 1);
        @(negedge clk); tmo_clr = 1'b1;
        @(negedge clk); tmo_clr = 1'b0;
        step(1);
        chk("R6 flag cleared", tmo_flag, 0);
    endtask

    task automatic t_inhibit_r7;
        int i0;
        wr_cfg(8'h2C);
        i0 = irq_cnt;
        sda = 1'b0; step(5);
        chk("R7 busy still set", busy, 1);
        scl = 1'b0; step(50);
        chk("R7 flag still set", tmo_flag, 1);
        scl = 1'b1; step(4);
        sda = 1'b1; step(5);
        chk("R7 busy still cleared", busy, 0);
        chk("R7 no irq", irq_cnt - i0, 0);
        @(negedge clk); tmo_clr = 1'b1;
        @(negedge clk); tmo_clr = 1'b0;
        wr_cfg(8'h24);
    endtask

    task automatic t_timing(input string req, input logic [7:0] c,
                            input int exp_h, input int exp_s);
        int kh = -1, ks = -1, nh = 0, ns = 0;
        wr_cfg(c);
        step(2);
        scl = 1'b0;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (hold_strb) begin kh = k; nh++; end
            if (setup_strb) begin ks = k; ns++; end
        end
        scl = 1'b1; step(5);
        chk({req, " hold cycle"}, kh, exp_h);
        chk({req, " setup cycle"}, ks, exp_s);
        chk({req, " single strobes"}, nh + ns, 2);
    endtask

    task automatic t_read_r10;
        wr_cfg(8'hFF);
        chk("R10 readback masks", cfg_rdata, 8'h7C);
        wr_cfg(8'h24);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset;
        t_disabled_r1;
        t_start_r2;
        t_stop_r3;
        t_free_r4;
        t_low_r5;
        t_clear_r6;
        t_inhibit_r7;
        t_timing("R8", 8'h24, 5, 9);
        t_timing("R9", 8'h34, 14, 25);
        t_read_r10;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule